// File: doc/BRIEF.md
# Shared Interrupt Distributor with Routing

This block is the global stage of a small multiprocessor interrupt controller. It takes the shared external interrupt lines, which carry interrupt IDs 32 and up, and detects each one according to its own trigger mode. It then hands every pending interrupt to exactly one CPU. Each interrupt is routed in one of two ways. In fixed mode it goes only to one named CPU. In automatic mode it goes to whichever CPU is free first. There is no way to route an interrupt to an arbitrary subset of CPUs.

Software sets the block up through a 32-bit register port. That port holds a global enable, packed 2-bit trigger codes and one routing word per shared interrupt. Each CPU interface sees a request line and an 8-bit interrupt ID. The CPU takes the interrupt with an acknowledge pulse, which puts it in service. It closes the interrupt with an end-of-interrupt pulse. Each CPU holds at most one shared interrupt at a time, either presented or in service. Priority levels, nesting, private interrupts and inter-processor signalling are not part of this block.

Top module: `shared_irq_dist`

## Requirements
- R1: Bit 0 of the word at offset 0x0 is the global enable and resets to 0. While it is 0, no request line rises. Offset 0x0 reads back the enable in bit 0, with all other bits 0.
- R2: Trigger codes are 2 bits wide: 0 = level, active high; 1 = level, active low; 2 = rising edge; 3 = falling edge. Every code resets to 0.
- R3: Trigger codes live at offset 0x100 + 4*w. Source k (ID 32+k) uses bits [2j+1:2j] of word w, where w = k/16 and j = k%16. Written codes read back in place, and unused bits read 0.
- R4: The routing word of source k is at offset 0x1000 + 4*k. When bit 31 is set, the source goes only to the CPU whose index is in bits [7:0]. When bit 31 is clear, including the reset value 0, routing is automatic. Bits 31 and 7:0 read back, and bits 30:8 read 0.
- R5: A CPU can take a new interrupt only when it is eligible. It is eligible when its cpu_en is high, it is presenting nothing and it has nothing in service. In each cycle, CPUs are served in ascending index order. Each CPU takes a pending interrupt that none of the lower-numbered CPUs has taken in that cycle.
- R6: A presented source k shows irq_id = 32+k. When a CPU could take several routable pending sources, it takes the one with the lowest k.
- R7: Edge-mode inputs pass through a two-flop synchroniser. An edge is held pending until the interrupt is acknowledged. A request appears three clocks after the edge is applied.
- R8: A level-mode source is pending while its input, with the polarity applied, is active. A request appears two clocks after the input is applied. A presented or in-service source is not presented again. After end-of-interrupt, it is presented again if its input is still active.
- R9: A fixed route whose CPU index is NUM_CPU or higher is undeliverable. The source stays pending, and it is delivered once its routing word is rewritten.
- R10: A request holds its ID steady until the CPU acknowledges it. The request drops the clock after acknowledge, and the source then stays in service until cpu_eoi. An acknowledge with no request, or an end-of-interrupt with nothing in service, does nothing.
- R11: A CPU presents at most one interrupt at a time, and no source is ever presented to two CPUs at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| src_in | input | NUM_SRC | Shared interrupt inputs, bit k is ID 32+k |
| cpu_en | input | NUM_CPU | Per-CPU interface enable |
| cpu_ack | input | NUM_CPU | Per-CPU acknowledge pulse |
| cpu_eoi | input | NUM_CPU | Per-CPU end-of-interrupt pulse |
| irq_req | output | NUM_CPU | Per-CPU request line |
| irq_id | output | 8*NUM_CPU | Per-CPU interrupt ID, byte c belongs to CPU c |

## Verification
The hardest case to reach is the one where the allocation order matters. This needs several CPUs eligible in the same cycle, with automatic, fixed and undeliverable sources all pending and some of them already in service. The directed part of the bench reaches it by filling the CPUs one at a time. It then frees individual CPUs with acknowledge and end-of-interrupt pulses, and it rewrites routing words while sources are held active. A long random phase then mixes input toggles, acknowledges, end-of-interrupts, interface enables and register rewrites. A behavioural model compares the request lines and IDs against the design on every clock.

// File: rtl/shared_irq_dist.sv
module shared_irq_dist #(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [15:0]          reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_SRC-1:0]   src_in,
  input  logic [NUM_CPU-1:0]   cpu_en,
  input  logic [NUM_CPU-1:0]   cpu_ack,
  input  logic [NUM_CPU-1:0]   cpu_eoi,
  output logic [NUM_CPU-1:0]   irq_req,
  output logic [NUM_CPU*8-1:0] irq_id
);
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [7:0] BASE_ID = 8'd32;

  logic               dist_en;
  logic [1:0]         mode [NUM_SRC];
  logic [NUM_SRC-1:0] rfix;
  logic [7:0]         rcpu [NUM_SRC];
  logic [NUM_SRC-1:0] s1, s2, s3, elat, active, busy, ack_hit, edge_det;
  logic [NUM_CPU-1:0] pv, sv, gv;
  logic [IW-1:0]      pidx [NUM_CPU];
  logic [IW-1:0]      sidx [NUM_CPU];
  logic [IW-1:0]      gidx [NUM_CPU];

  wire sel_ctl = reg_addr == 16'h0000;
  wire sel_trg = reg_addr[15:8] == 8'h01 && reg_addr[1:0] == 2'b00;
  wire sel_rte = reg_addr[15:12] == 4'h1 && reg_addr[1:0] == 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dist_en <= 1'b0;
      rfix    <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        mode[i] <= 2'd0;
        rcpu[i] <= 8'd0;
      end
    end else if (reg_wr) begin
      if (sel_ctl) dist_en <= reg_wdata[0];
      for (int i = 0; i < NUM_SRC; i++) begin
        if (sel_trg && reg_addr[7:2] == 6'(i / 16))
          mode[i] <= reg_wdata[2*(i%16) +: 2];
        if (sel_rte && reg_addr[11:2] == 10'(i)) begin
          rfix[i] <= reg_wdata[31];
          rcpu[i] <= reg_wdata[7:0];
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_ctl) reg_rdata[0] = dist_en;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel_trg && reg_addr[7:2] == 6'(i / 16))
        reg_rdata[2*(i%16) +: 2] = mode[i];
      if (sel_rte && reg_addr[11:2] == 10'(i))
        reg_rdata = {rfix[i], 23'd0, rcpu[i]};
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign edge_det[i] = (mode[i] == 2'd2) ? (s2[i] & ~s3[i]) :
                         (mode[i] == 2'd3) ? (~s2[i] & s3[i]) : 1'b0;
    assign active[i]   = mode[i][1] ? elat[i] : (s2[i] ^ mode[i][0]);
  end

  always_comb begin
    busy    = '0;
    ack_hit = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (pv[c]) busy[pidx[c]] = 1'b1;
      if (sv[c]) busy[sidx[c]] = 1'b1;
      if (pv[c] && cpu_ack[c]) ack_hit[pidx[c]] = 1'b1;
    end
  end

  always_comb begin
    logic [NUM_SRC-1:0] taken;
    taken = '0;
    gv    = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      gidx[c] = '0;
      if (dist_en && cpu_en[c] && !pv[c] && !sv[c])
        for (int i = NUM_SRC - 1; i >= 0; i--)
          if (active[i] && !busy[i] && !taken[i] && (!rfix[i] || rcpu[i] == 8'(c))) begin
            gv[c]   = 1'b1;
            gidx[c] = IW'(i);
          end
      if (gv[c]) taken[gidx[c]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {s1, s2, s3, elat} <= '0;
      pv <= '0;
      sv <= '0;
      for (int c = 0; c < NUM_CPU; c++) begin
        pidx[c] <= '0;
        sidx[c] <= '0;
      end
    end else begin
      s1 <= src_in;
      s2 <= s1;
      s3 <= s2;
      for (int i = 0; i < NUM_SRC; i++)
        elat[i] <= mode[i][1] & ((elat[i] & ~ack_hit[i]) | edge_det[i]);
      for (int c = 0; c < NUM_CPU; c++) begin
        if (pv[c] && cpu_ack[c]) begin
          pv[c]   <= 1'b0;
          sv[c]   <= 1'b1;
          sidx[c] <= pidx[c];
        end else if (gv[c]) begin
          pv[c]   <= 1'b1;
          pidx[c] <= gidx[c];
        end
        if (sv[c] && cpu_eoi[c]) sv[c] <= 1'b0;
      end
    end
  end

  assign irq_req = pv;
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_out
    assign irq_id[c*8 +: 8] = pv[c] ? BASE_ID + 8'(pidx[c]) : 8'd0;
  end
endmodule

module shared_irq_dist_chk #(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 dist_en,
  input logic [NUM_CPU-1:0]   cpu_en,
  input logic [NUM_CPU-1:0]   cpu_ack,
  input logic [NUM_CPU-1:0]   irq_req,
  input logic [NUM_CPU*8-1:0] irq_id
);
  initial begin
    // R6
    src_count_chk: assert (NUM_SRC >= 1 && NUM_SRC <= 224 && NUM_CPU >= 1 && NUM_CPU <= 256);
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    // R1
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dist_en |=> !$rose(irq_req[c]));
    // R5
    cpu_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_en[c] |=> !$rose(irq_req[c]));
    // R10
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[c] && cpu_ack[c] |=> !irq_req[c]);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[c] && !cpu_ack[c] |=> irq_req[c] && $stable(irq_id[c*8 +: 8]));
    // R6
    id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[c] |-> irq_id[c*8 +: 8] >= 8'd32 && irq_id[c*8 +: 8] < 8'(32 + NUM_SRC));
    for (genvar d = c + 1; d < NUM_CPU; d++) begin : g_pair
      // R11
      no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req[c] && irq_req[d] |-> irq_id[c*8 +: 8] != irq_id[d*8 +: 8]);
    end
  end
endmodule

bind shared_irq_dist shared_irq_dist_chk #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
  .cpu_ack(cpu_ack), .irq_req(irq_req), .irq_id(irq_id));

// File: tb/shared_irq_dist_tb.sv
module shared_irq_dist_tb;
  localparam int NC = 4;
  localparam int NS = 8;

  logic          clk = 0, rst_n = 0;
  logic          reg_wr = 0;
  logic [15:0]   reg_addr = 0;
  logic [31:0]   reg_wdata = 0;
  logic [31:0]   reg_rdata;
  logic [NS-1:0] src_in = 8'b0000_1000;
  logic [NC-1:0] cpu_en = '1, cpu_ack = '0, cpu_eoi = '0;
  logic [NC-1:0] irq_req;
  logic [NC*8-1:0] irq_id;

  int tests = 0, fails = 0;
  bit done = 0;
  string phase = "R1 reset";

  shared_irq_dist #(.NUM_CPU(NC), .NUM_SRC(NS)) u_dut (.*);

  always #5 clk = ~clk;

  // behavioural reference
  int m_en, m_mode[NS], m_fix[NS], m_cpu[NS];
  bit m_s1[NS], m_s2[NS], m_s3[NS], m_el[NS];
  bit m_pv[NC], m_sv[NC];
  int m_pi[NC], m_si[NC];

  always @(posedge clk) begin : model
    bit busy[NS], ackh[NS], act[NS], taken[NS];
    int g[NC];
    if (!rst_n) begin
      m_en = 0;
      for (int i = 0; i < NS; i++) begin
        m_mode[i] = 0; m_fix[i] = 0; m_cpu[i] = 0;
        m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0; m_el[i] = 0;
      end
      for (int c = 0; c < NC; c++) begin m_pv[c] = 0; m_sv[c] = 0; m_pi[c] = 0; m_si[c] = 0; end
    end else begin
      for (int i = 0; i < NS; i++) begin busy[i] = 0; ackh[i] = 0; taken[i] = 0; end
      for (int c = 0; c < NC; c++) begin
        if (m_pv[c]) busy[m_pi[c]] = 1;
        if (m_sv[c]) busy[m_si[c]] = 1;
        if (m_pv[c] && cpu_ack[c]) ackh[m_pi[c]] = 1;
      end
      for (int i = 0; i < NS; i++)
        act[i] = (m_mode[i] >= 2) ? m_el[i] : (m_s2[i] != (m_mode[i] == 1));
      for (int c = 0; c < NC; c++) begin
        g[c] = -1;
        if (m_en == 1 && cpu_en[c] && !m_pv[c] && !m_sv[c])
          for (int i = 0; i < NS; i++)
            if (g[c] < 0 && act[i] && !busy[i] && !taken[i] && (m_fix[i] == 0 || m_cpu[i] == c)) begin
              g[c] = i; taken[i] = 1;
            end
      end
      for (int i = 0; i < NS; i++) begin
        bit e;
        e = (m_mode[i] == 2) ? (m_s2[i] && !m_s3[i]) : (m_mode[i] == 3) ? (!m_s2[i] && m_s3[i]) : 0;
        m_el[i] = (m_mode[i] >= 2) && ((m_el[i] && !ackh[i]) || e);
      end
      for (int c = 0; c < NC; c++) begin
        bit eoi_ok;
        eoi_ok = m_sv[c] && cpu_eoi[c];
        if (m_pv[c] && cpu_ack[c]) begin m_pv[c] = 0; m_sv[c] = 1; m_si[c] = m_pi[c]; end
        else if (g[c] >= 0) begin m_pv[c] = 1; m_pi[c] = g[c]; end
        if (eoi_ok) m_sv[c] = 0;
      end
      for (int i = 0; i < NS; i++) begin m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = src_in[i]; end
      if (reg_wr) begin
        if (reg_addr == 16'h0) m_en = reg_wdata[0];
        if (reg_addr == 16'h100)
          for (int i = 0; i < NS; i++) m_mode[i] = (reg_wdata >> (2*i)) & 3;
        for (int i = 0; i < NS; i++)
          if (reg_addr == 16'h1000 + 16'(4*i)) begin m_fix[i] = reg_wdata[31]; m_cpu[i] = reg_wdata[7:0]; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < NC; c++) begin
        tests++;
        if (irq_req[c] !== m_pv[c] || (m_pv[c] && irq_id[c*8 +: 8] !== 8'(32 + m_pi[c]))) begin
          fails++;
          $display("FAIL %s cpu%0d: req=%0b id=%0d expected req=%0b id=%0d",
                   phase, c, irq_req[c], irq_id[c*8 +: 8], m_pv[c], 32 + m_pi[c]);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    tick(1);
    reg_wr = 0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a; #1;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic ack(input int c);
    cpu_ack[c] = 1; tick(1); cpu_ack[c] = 0;
  endtask

  task automatic eoi(input int c);
    cpu_eoi[c] = 1; tick(1); cpu_eoi[c] = 0;
  endtask

  function automatic int idof(input int c);
    return irq_id[c*8 +: 8];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    rd_chk(16'h0000, 32'h0, "R1 enable reset value");
    chk(irq_req == 0, "R10 no request after reset", irq_req, 0);
    rd_chk(16'h0100, 32'h0, "R2 trigger codes reset to 0");
    rd_chk(16'h1008, 32'h0, "R4 route resets to automatic");

    phase = "R3 trigger packing";
    wr(16'h0100, 32'hFFFF_A5C3);
    rd_chk(16'h0100, 32'h0000_A5C3, "R3 trigger readback");
    wr(16'h0100, 32'h0000_0E40);
    rd_chk(16'h0100, 32'h0000_0E40, "R3 trigger layout");

    phase = "R4 route";
    wr(16'h1018, 32'h8000_0103);
    rd_chk(16'h1018, 32'h8000_0003, "R4 route readback");

    phase = "R1 disabled";
    src_in[0] = 1;
    tick(6);
    chk(irq_req == 0, "R1 no request while disabled", irq_req, 0);
    wr(16'h0000, 32'h1);
    rd_chk(16'h0000, 32'h1, "R1 enable readback");
    phase = "R5 automatic";
    tick(2);
    chk(irq_req[0] && idof(0) == 32, "R5 lowest CPU takes ID 32", idof(0), 32);

    phase = "R6 lowest id";
    src_in[2] = 1; src_in[1] = 1;
    tick(3);
    chk(idof(1) == 33, "R6 cpu1 takes ID 33", idof(1), 33);
    chk(idof(2) == 34, "R6 cpu2 takes ID 34", idof(2), 34);

    phase = "R10 ack";
    ack(0);
    tick(1);
    chk(irq_req[0] == 0, "R10 request drops after ack", irq_req[0], 0);
    phase = "R8 in service";
    tick(4);
    chk(irq_req[0] == 0, "R8 not re-presented in service", irq_req[0], 0);
    eoi(0);
    tick(2);
    chk(irq_req[0] && idof(0) == 32, "R8 re-presented after eoi", idof(0), 32);
    ack(0); src_in[0] = 0; tick(3); eoi(0);
    tick(3);
    chk(irq_req[0] == 0, "R8 inactive level not presented", irq_req[0], 0);

    phase = "R2 active low";
    src_in[3] = 0;
    tick(3);
    chk(irq_req[0] && idof(0) == 35, "R2 active-low source", idof(0), 35);
    ack(0); src_in[3] = 1; tick(3); eoi(0); tick(2);

    phase = "R7 rising edge";
    src_in[4] = 1; tick(1); src_in[4] = 0;
    tick(3);
    chk(irq_req[0] && idof(0) == 36, "R7 rising pulse latched", idof(0), 36);
    ack(0); tick(2); eoi(0); tick(4);
    chk(irq_req[0] == 0, "R7 latch cleared by ack", irq_req[0], 0);

    phase = "R7 falling edge";
    src_in[5] = 1; tick(4);
    chk(irq_req[0] == 0, "R7 rise ignored in falling mode", irq_req[0], 0);
    src_in[5] = 0; tick(4);
    chk(irq_req[0] && idof(0) == 37, "R7 falling edge", idof(0), 37);
    ack(0); tick(1); eoi(0); tick(1);

    phase = "R4 fixed route";
    src_in[6] = 1; tick(3);
    chk(irq_req[3] && idof(3) == 38, "R4 fixed route to cpu3", idof(3), 38);
    chk(irq_req[0] == 0, "R4 cpu0 skipped for fixed route", irq_req[0], 0);

    phase = "R9 out of range";
    wr(16'h101C, 32'h8000_0009);
    src_in[7] = 1; tick(8);
    chk(irq_req[0] == 0, "R9 undeliverable stays off", irq_req[0], 0);
    wr(16'h101C, 32'h0);
    tick(2);
    chk(irq_req[0] && idof(0) == 39, "R9 delivered after rewrite", idof(0), 39);

    phase = "R5 cpu disabled";
    ack(0); cpu_en[0] = 0; tick(1); eoi(0); tick(4);
    chk(irq_req[0] == 0, "R5 disabled CPU skipped", irq_req[0], 0);
    ack(1); src_in[1] = 0; tick(1); eoi(1); tick(3);
    chk(irq_req[1] && idof(1) == 39, "R5 next eligible CPU", idof(1), 39);
    cpu_en[0] = 1;

    phase = "R10 stray ack/eoi";
    cpu_ack[0] = 1; cpu_eoi[0] = 1; tick(1); cpu_ack[0] = 0; cpu_eoi[0] = 0; tick(2);

    phase = "R11 random mix";
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 20) src_in[$urandom_range(0, NS-1)] ^= 1'b1;
      cpu_ack = 4'($urandom_range(0, 15) & $urandom_range(0, 15));
      cpu_eoi = 4'($urandom_range(0, 15) & $urandom_range(0, 15));
      cpu_en  = 4'($urandom_range(0, 15) | $urandom_range(0, 15));
      if (r == 97) begin reg_addr = 16'h100; reg_wdata = $urandom; reg_wr = 1; end
      else if (r == 98) begin
        reg_addr = 16'h1000 + 16'(4*$urandom_range(0, NS-1));
        reg_wdata = ($urandom_range(0, 1) == 1) ? (32'h8000_0000 | 32'($urandom_range(0, 5))) : 32'h0;
        reg_wr = 1;
      end else if (r == 99) begin reg_addr = 16'h0; reg_wdata = 32'($urandom_range(0, 3) != 0); reg_wr = 1; end
      else reg_wr = 0;
      tick(1);
    end
    reg_wr = 0; cpu_ack = 0; cpu_eoi = 0;
    tick(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule